// File: doc/BRIEF.md
# Nine-Bit Word Byte Packer

This block takes a stream of 8-bit values, each tagged as data or command, and repacks it so that a serial shifter limited to 8-bit words still puts 9-bit words on the wire. Every 9-bit word is a data/command flag followed by the eight value bits, most significant bit first. The words run back to back across byte boundaries, so eight of them fill exactly nine output bytes. Slots that are left unused in a block are zero words, which the receiving display controller treats as no-operation.

Data values are collected into a group of eight. The group goes out when it is full, or earlier when the flush input closes it. A command always travels in a block of its own, placed in the last word slot behind seven zero words. A pair-swap mode reverses the order of each two consecutive data values, so that a 16-bit pixel stored low byte first reaches the wire high byte first. Both sides use valid/ready handshakes. Serial clocking and chip select belong to the shifter and are outside this block.

Top module: `nineword_packer`

## Requirements
- R1: Each word is {flag, value[7:0]}, with `in_dc`=1 marking data (flag 1) and `in_dc`=0 marking a command (flag 0). The block is the concatenation of word 0 through word 7, MSB first, and output byte k holds bits [71-8k : 64-8k] of it.
- R2: A block is always exactly nine output bytes. `out_last` is high on the ninth byte only, and `out_valid` is low in the cycle after that byte is taken.
- R3: When the eighth data value of a group is accepted, `out_valid` rises in the next cycle and the block carries the eight values in arrival order.
- R4: A command accepted while the group is empty produces a block of seven zero words followed by the command word with flag 0.
- R5: A flush with one or more values pending closes the group and fills the unused word slots with zero words. A flush in the same cycle as an accepted data value includes that value.
- R6: A flush with no values pending and no value accepted produces no output.
- R7: A command presented while data values are pending is held (`in_ready` low) until the pending group has gone out, padded as in R5. It then goes out in a block of its own as in R4.
- R8: With `swap_pairs`=1, the n-th data value of a group (n counted from 0) occupies word slot n XOR 1. A group flushed with an odd count leaves the partner slot of its last value as a zero word.
- R9: `in_ready` is low while a block is being sent. While `out_valid` is high and `out_ready` low, `out_byte` and `out_last` hold their values.
- R10: After reset `out_valid` is low, `in_ready` is high and no values are pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| swap_pairs | input | 1 | 1: swap each pair of data values within a group |
| in_valid | input | 1 | Input value present |
| in_ready | output | 1 | Input value can be taken this cycle |
| in_dc | input | 1 | 1: data, 0: command |
| in_byte | input | DATA_W | Input value |
| in_flush | input | 1 | Close the pending group |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Shifter takes the output byte |
| out_byte | output | 8 | Output byte |
| out_last | output | 1 | Ninth byte of a block |

## Verification
On every cycle the assertions check the framing and the handshakes: a block ends on its ninth byte, the output holds during a stall, no input is taken during a block, a full or flushed group starts a block on the next cycle, and an empty flush stays silent. The actual bit layout cannot be checked that way. This covers the flag positions, the zero-word padding, the command placement and the pair swap. Only the directed scenarios show these, by comparing every captured byte against a model that concatenates 9-bit words bit by bit.

// File: rtl/nineword_pkg.sv
package nineword_pkg;

  typedef enum logic {
    ST_COLLECT = 1'b0,
    ST_EMIT    = 1'b1
  } pk_state_e;

  // Word slot that an incoming value occupies inside the block.
  function automatic int unsigned slot_for(input int unsigned cnt,
                                           input logic swap,
                                           input logic is_cmd,
                                           input int unsigned group);
    if (is_cmd)
      return group - 1;
    if (swap)
      return cnt ^ 1;
    return cnt;
  endfunction

  // Most significant bit position of a word slot in the flattened block.
  function automatic int unsigned word_msb(input int unsigned slot,
                                           input int unsigned word_w,
                                           input int unsigned block_w);
    return block_w - 1 - slot * word_w;
  endfunction

endpackage

// File: rtl/nineword_collector.sv
module nineword_collector #(
  parameter int DATA_W = 8,
  parameter int GROUP  = 8,
  localparam int WORD_W  = DATA_W + 1,
  localparam int BLOCK_W = GROUP * WORD_W,
  localparam int CNT_W   = $clog2(GROUP + 1),
  localparam int SLOT_W  = $clog2(GROUP)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_i,
  input  logic               wr_en_i,
  input  logic               wr_cmd_i,
  input  logic [SLOT_W-1:0]  wr_slot_i,
  input  logic [WORD_W-1:0]  wr_word_i,
  output logic [CNT_W-1:0]   count_o,
  output logic [BLOCK_W-1:0] block_o
);

  logic [CNT_W-1:0] count_q;

  // One register per word slot; unwritten slots stay zero (no-op words).
  for (genvar g = 0; g < GROUP; g++) begin : g_slot
    localparam int MSB = nineword_pkg::word_msb(g, WORD_W, BLOCK_W);
    logic [WORD_W-1:0] w_q;
    logic              hit;

    assign hit = wr_en_i && (wr_slot_i == SLOT_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        w_q <= '0;
      else if (clear_i)
        w_q <= '0;
      else if (hit)
        w_q <= wr_word_i;
    end

    assign block_o[MSB -: WORD_W] = w_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count_q <= '0;
    else if (clear_i)
      count_q <= '0;
    else if (wr_en_i && wr_cmd_i)
      count_q <= CNT_W'(GROUP);
    else if (wr_en_i)
      count_q <= count_q + 1'b1;
  end

  assign count_o = count_q;

endmodule

// File: rtl/nineword_serializer.sv
module nineword_serializer #(
  parameter int BLOCK_W = 72,
  localparam int NBYTES = BLOCK_W / 8,
  localparam int IDX_W  = $clog2(NBYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active_i,
  input  logic               ready_i,
  input  logic [BLOCK_W-1:0] block_i,
  output logic [7:0]         byte_o,
  output logic               last_o,
  output logic               done_o
);

  logic [IDX_W-1:0]   idx_q;
  logic [BLOCK_W-1:0] shifted;
  logic               step;

  assign shifted = block_i << (8 * idx_q);
  assign byte_o  = shifted[BLOCK_W-1 -: 8];
  assign last_o  = (idx_q == IDX_W'(NBYTES - 1));
  assign step    = active_i && ready_i;
  assign done_o  = step && last_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx_q <= '0;
    else if (done_o)
      idx_q <= '0;
    else if (step)
      idx_q <= idx_q + 1'b1;
  end

endmodule

// File: rtl/nineword_packer.sv
module nineword_packer #(
  parameter int DATA_W = 8,
  parameter int GROUP  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swap_pairs,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_dc,
  input  logic [DATA_W-1:0] in_byte,
  input  logic              in_flush,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_byte,
  output logic              out_last
);

  import nineword_pkg::*;

  localparam int WORD_W  = DATA_W + 1;
  localparam int BLOCK_W = GROUP * WORD_W;
  localparam int CNT_W   = $clog2(GROUP + 1);
  localparam int SLOT_W  = $clog2(GROUP);

  pk_state_e state_q, state_d;

  logic [CNT_W-1:0]   grp_count;
  logic [BLOCK_W-1:0] block;
  logic [SLOT_W-1:0]  wr_slot;

  // Named internal events.
  logic collecting;
  logic cmd_blocked;
  logic accept;
  logic accept_cmd;
  logic accept_data;
  logic flush_close;
  logic full_close;
  logic go_emit;
  logic block_done;

  assign collecting  = (state_q == ST_COLLECT);
  assign cmd_blocked = collecting && in_valid && !in_dc && (grp_count != '0);
  assign in_ready    = collecting && !cmd_blocked;
  assign accept      = in_valid && in_ready;
  assign accept_cmd  = accept && !in_dc;
  assign accept_data = accept && in_dc;
  assign full_close  = accept_data && (grp_count == CNT_W'(GROUP - 1));
  assign flush_close = collecting && in_flush && !accept_cmd &&
                       ((grp_count != '0) || accept_data);
  assign go_emit     = accept_cmd || cmd_blocked || full_close || flush_close;

  assign wr_slot = SLOT_W'(slot_for(int'(grp_count), swap_pairs, !in_dc, GROUP));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_COLLECT: if (go_emit)    state_d = ST_EMIT;
      ST_EMIT:    if (block_done) state_d = ST_COLLECT;
      default:                    state_d = ST_COLLECT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state_q <= ST_COLLECT;
    else
      state_q <= state_d;
  end

  nineword_collector #(
    .DATA_W (DATA_W),
    .GROUP  (GROUP)
  ) collect_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (block_done),
    .wr_en_i   (accept),
    .wr_cmd_i  (!in_dc),
    .wr_slot_i (wr_slot),
    .wr_word_i ({in_dc, in_byte}),
    .count_o   (grp_count),
    .block_o   (block)
  );

  assign out_valid = (state_q == ST_EMIT);

  nineword_serializer #(
    .BLOCK_W (BLOCK_W)
  ) ser_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (out_valid),
    .ready_i  (out_ready),
    .block_i  (block),
    .byte_o   (out_byte),
    .last_o   (out_last),
    .done_o   (block_done)
  );

endmodule

// File: rtl/nineword_packer_chk.sv
module nineword_packer_chk #(
  parameter int DATA_W = 8,
  parameter int GROUP  = 8,
  localparam int NBYTES = (GROUP * (DATA_W + 1)) / 8,
  localparam int IDX_W  = $clog2(NBYTES),
  localparam int CNT_W  = $clog2(GROUP + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_dc,
  input logic             in_flush,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_byte,
  input logic             out_last,
  input logic [CNT_W-1:0] grp_count,
  input logic             accept_data
);

  logic [IDX_W-1:0] beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      beat_q <= '0;
    else if (out_valid && out_ready)
      beat_q <= out_last ? '0 : beat_q + 1'b1;
  end

  p_last_only_ninth_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (beat_q == IDX_W'(NBYTES - 1)));

  p_ninth_is_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && beat_q == IDX_W'(NBYTES - 1)) |-> out_last);

  p_block_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);

  p_full_emits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_data && grp_count == CNT_W'(GROUP - 1)) |=> out_valid);

  p_flush_emits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_data && in_flush) |=> out_valid);

  p_empty_flush_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid && in_flush && grp_count == '0) |=> !out_valid);

  p_cmd_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && in_valid && !in_dc && grp_count != '0) |-> !in_ready);

  p_busy_no_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_last)));

endmodule

bind nineword_packer nineword_packer_chk #(
  .DATA_W (DATA_W),
  .GROUP  (GROUP)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_dc       (in_dc),
  .in_flush    (in_flush),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_byte    (out_byte),
  .out_last    (out_last),
  .grp_count   (grp_count),
  .accept_data (accept_data)
);

// File: tb/nineword_packer_tb_top.sv
`timescale 1ns/1ps
module nineword_packer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       swap_pairs = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       in_dc = 1'b1;
  logic [7:0] in_byte = 8'h00;
  logic       in_flush = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_byte;
  logic       out_last;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  bit stall_en = 0;
  int cyc      = 0;

  logic [7:0] cap_b [0:511];
  logic       cap_l [0:511];
  int         cap_n = 0;
  logic [7:0] exp_b [0:511];
  logic       exp_l [0:511];
  int         exp_n = 0;
  int         cmp_i = 0;
  logic [8:0] wl [0:7];
  int         wn = 0;

  always #10 clk = ~clk;

  nineword_packer dut_i (
    .clk(clk), .rst_n(rst_n), .swap_pairs(swap_pairs),
    .in_valid(in_valid), .in_ready(in_ready), .in_dc(in_dc),
    .in_byte(in_byte), .in_flush(in_flush),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_byte(out_byte), .out_last(out_last)
  );

  // Output side: set ready at the falling edge, then record a handshake.
  always begin
    @(negedge clk);
    cyc++;
    out_ready = !stall_en || (cyc % 3 != 0);
    #1;
    if (out_valid && out_ready && cap_n < 512) begin
      cap_b[cap_n] = out_byte;
      cap_l[cap_n] = out_last;
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // Model: list of 9-bit words, closed into nine bytes bit by bit.
  task automatic model_word(input logic dc, input logic [7:0] v);
    wl[wn] = {dc, v};
    wn++;
  endtask

  task automatic model_slot(input int s, input logic dc, input logic [7:0] v);
    wl[s] = {dc, v};
  endtask

  task automatic model_close();
    logic [7:0] acc;
    int nb;
    acc = 8'h00;
    nb = 0;
    for (int w = 0; w < 8; w++) begin
      for (int b = 8; b >= 0; b--) begin
        acc = {acc[6:0], wl[w][b]};
        nb++;
        if (nb % 8 == 0) begin
          exp_b[exp_n] = acc;
          exp_l[exp_n] = (nb == 72);
          exp_n++;
        end
      end
    end
    for (int w = 0; w < 8; w++) wl[w] = 9'h000;
    wn = 0;
  endtask

  task automatic put(input logic dc, input logic [7:0] v, input logic fl);
    @(negedge clk);
    in_valid = 1'b1;
    in_dc    = dc;
    in_byte  = v;
    in_flush = fl;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_flush = 1'b0;
  endtask

  task automatic flush_pulse();
    @(negedge clk);
    in_flush = 1'b1;
    @(posedge clk);
    #1;
    in_flush = 1'b0;
  endtask

  task automatic compare(input string req);
    int t;
    t = 0;
    while (cap_n < exp_n && t < 600) begin
      @(posedge clk);
      t++;
    end
    repeat (4) @(posedge clk);
    chk(cap_n == exp_n, req, cap_n, exp_n);
    while (cmp_i < exp_n && cmp_i < cap_n) begin
      chk(cap_b[cmp_i] === exp_b[cmp_i], req, int'(cap_b[cmp_i]), int'(exp_b[cmp_i]));
      chk(cap_l[cmp_i] === exp_l[cmp_i], req, int'(cap_l[cmp_i]), int'(exp_l[cmp_i]));
      cmp_i++;
    end
    cmp_i = exp_n;
    cap_n = exp_n;
  endtask

  task automatic t_reset_r10();
    #1;
    chk(out_valid == 1'b0, "R10 out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R10 in_ready", int'(in_ready), 1);
  endtask

  task automatic t_full_group_r3();
    logic [7:0] v [0:7] = '{8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h81, 8'h7E, 8'h12, 8'hC9};
    for (int i = 0; i < 8; i++) begin
      put(1'b1, v[i], 1'b0);
      model_word(1'b1, v[i]);
    end
    model_close();
    compare("R3 R1 R2 full data group");
  endtask

  task automatic t_command_r4();
    put(1'b0, 8'h2C, 1'b0);
    model_slot(7, 1'b0, 8'h2C);
    model_close();
    compare("R4 lone command block");
  endtask

  task automatic t_partial_flush_r5();
    put(1'b1, 8'h11, 1'b0);
    put(1'b1, 8'hE7, 1'b0);
    put(1'b1, 8'h40, 1'b0);
    flush_pulse();
    model_word(1'b1, 8'h11);
    model_word(1'b1, 8'hE7);
    model_word(1'b1, 8'h40);
    model_close();
    compare("R5 flush after three values");
    put(1'b1, 8'h9B, 1'b0);
    put(1'b1, 8'h06, 1'b1);
    model_word(1'b1, 8'h9B);
    model_word(1'b1, 8'h06);
    model_close();
    compare("R5 flush with last value");
  endtask

  task automatic t_empty_flush_r6();
    flush_pulse();
    repeat (20) @(posedge clk);
    chk(cap_n == exp_n, "R6 empty flush output count", cap_n, exp_n);
    chk(out_valid == 1'b0, "R6 empty flush out_valid", int'(out_valid), 0);
  endtask

  task automatic t_cmd_pending_r7();
    put(1'b1, 8'hD2, 1'b0);
    put(1'b1, 8'h5F, 1'b0);
    put(1'b0, 8'h29, 1'b0);
    model_word(1'b1, 8'hD2);
    model_word(1'b1, 8'h5F);
    model_close();
    model_slot(7, 1'b0, 8'h29);
    model_close();
    compare("R7 command after pending data");
  endtask

  task automatic t_swap_r8();
    swap_pairs = 1'b1;
    for (int i = 0; i < 8; i++) begin
      put(1'b1, 8'(8'h11 * (i + 1)), 1'b0);
      model_slot(i ^ 1, 1'b1, 8'(8'h11 * (i + 1)));
    end
    model_close();
    compare("R8 swapped full group");
    put(1'b1, 8'h5A, 1'b1);
    model_slot(1, 1'b1, 8'h5A);
    model_close();
    compare("R8 swapped odd flush");
    swap_pairs = 1'b0;
  endtask

  task automatic t_stall_r9();
    stall_en = 1;
    for (int i = 0; i < 8; i++) begin
      put(1'b1, 8'(8'h3B + 17 * i), 1'b0);
      model_word(1'b1, 8'(8'h3B + 17 * i));
    end
    model_close();
    @(negedge clk);
    in_valid = 1'b1;
    in_dc    = 1'b1;
    in_byte  = 8'hEE;
    #2;
    chk(in_ready == 1'b0, "R9 in_ready during block", int'(in_ready), 0);
    in_valid = 1'b0;
    compare("R9 output under backpressure");
    stall_en = 0;
  endtask

  initial begin
    for (int w = 0; w < 8; w++) wl[w] = 9'h000;
    repeat (3) @(posedge clk);
    t_reset_r10();
    @(negedge clk);
    rst_n = 1'b1;
    t_full_group_r3();
    t_command_r4();
    t_partial_flush_r5();
    t_empty_flush_r6();
    t_cmd_pending_r7();
    t_swap_r8();
    t_stall_r9();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule